// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block picks one resident warp per clock and sends one instruction for it to a 32-lane execution array. One issue drives all lanes of the warp in lockstep. Each warp slot shows three flags for its next instruction: whether the slot is occupied, whether that instruction reads a result the same warp produced earlier, and whether it writes a result. A register result cannot be read until a fixed number of cycles after the instruction that produced it has issued. The scheduler does not stall the pipe while it waits for such a result. It issues a different warp that is ready instead, so a large enough pool of warps keeps the issue slot full.

Each slot has its own countdown. The countdown is armed when a writing instruction of that warp issues and it runs down by one each clock. A dependent instruction becomes eligible only when its warp's countdown has reached zero. Eligible warps are served in round-robin order, starting from the slot after the last one granted. A cycle in which no warp is eligible is reported on a one-cycle idle pulse, which can be counted outside the block as a busy/idle statistic. Decode, the register file and the datapath are outside this block. The environment advances a warp's descriptor after that warp has been granted.

Top module: `warp_issue_sched`

## Requirements
- R1: In every cycle out of reset, exactly one of these holds: the block issues one instruction from exactly one warp (`issue_valid`=1, with its slot number on `issue_warp_id`), or it issues nothing.
- R2: A slot whose `warp_valid` bit is 0 is never granted.
- R3: Eligible warps are granted in round-robin order. The search starts at the slot after the last one granted and wraps from the highest slot to slot 0. After reset the search starts at slot 0.
- R4: Suppose an instruction with its `warp_wr` bit set issues for warp w in cycle t, with the default latency of 24. A `warp_dep` instruction of warp w then cannot issue before cycle t+24. If nothing else holds it back, it issues in cycle t+24.
- R5: When a warp is held by its countdown, the scheduler grants another eligible warp in the same cycle instead of going idle.
- R6: An instruction whose `warp_dep` bit is 0 is eligible whatever its warp's countdown holds.
- R7: Suppose 24 or more valid warps each issue only dependent writing instructions. The issue slot is then busy in every cycle. With 23 such warps, exactly one idle cycle occurs in each 24-cycle period.
- R8: `idle_cycle` is 1 in exactly the cycles where `issue_valid` is 0.
- R9: Reset clears every countdown, so a dependent instruction is eligible in the first cycle after reset even if its warp was waiting before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NUM_WARPS | Bit w is 1 when slot w holds a resident warp |
| warp_dep | input | NUM_WARPS | Bit w is 1 when the next instruction of warp w reads an earlier result of that warp |
| warp_wr | input | NUM_WARPS | Bit w is 1 when the next instruction of warp w writes a result |
| issue_valid | output | 1 | An instruction is issued in this cycle |
| issue_warp_id | output | $clog2(NUM_WARPS) | Slot of the issued warp |
| idle_cycle | output | 1 | No warp is eligible in this cycle |

## Verification
The hardest case to reach from the ports is the steady state in which every warp is blocked on its own countdown and the round-robin rotation lands on each warp exactly as its countdown expires. Only then does the boundary between a full issue slot and one bubble per period show up. The stimulus holds 24 and then 23 slots with descriptors that are both dependent and writing for hundreds of cycles. It checks the grant order against slot number modulo the pool size, and checks the exact number of idle cycles. A separate test resets a warp partway through its countdown to show that the countdown is cleared.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

   // Default pool geometry and dependency latency
   localparam int DEF_NUM_WARPS = 32;
   localparam int DEF_RAW_LAT   = 24;
   localparam int DEF_LANES     = 32;

   // Width of a countdown able to hold lat-1
   function automatic int cnt_width(input int lat);
      return (lat > 2) ? $clog2(lat) : 1;
   endfunction

   // Id width for a pool of n slots
   function automatic int id_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/warp_raw_timer.sv
module warp_raw_timer #(
   parameter int RAW_LAT = 24,
   parameter int CW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   output logic [CW-1:0] remain,
   output logic          clear
);

   localparam logic [CW-1:0] LOAD_VAL = CW'(RAW_LAT - 1);

   generate
      if (RAW_LAT <= 1) begin : g_no_wait
         // A result is readable on the next cycle: nothing to count
         assign remain = '0;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (arm)
               cnt_q <= LOAD_VAL;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign remain = cnt_q;
      end
   endgenerate

   assign clear = (remain == '0);

endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker #(
   parameter int N   = 32,
   parameter int IDW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req,
   output logic           gnt_valid,
   output logic [IDW-1:0] gnt_id
);

   localparam logic [IDW-1:0] LAST = IDW'(N - 1);

   logic [IDW-1:0] start_q;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_id    = '0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = (int'(start_q) + k) % N;
         if (!gnt_valid && req[idx]) begin
            gnt_valid = 1'b1;
            gnt_id    = IDW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         start_q <= '0;
      else if (gnt_valid)
         start_q <= (gnt_id == LAST) ? '0 : gnt_id + 1'b1;
   end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import warp_sched_pkg::*;
#(
   parameter int NUM_WARPS = DEF_NUM_WARPS,
   parameter int RAW_LAT   = DEF_RAW_LAT,
   parameter int LANES     = DEF_LANES,
   localparam int IDW      = id_width(NUM_WARPS),
   localparam int CW       = cnt_width(RAW_LAT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] warp_valid,
   input  logic [NUM_WARPS-1:0] warp_dep,
   input  logic [NUM_WARPS-1:0] warp_wr,
   output logic                 issue_valid,
   output logic [IDW-1:0]       issue_warp_id,
   output logic                 idle_cycle
);

   generate
      if (NUM_WARPS < 2) begin : g_bad_pool
         $error("warp_issue_sched: NUM_WARPS must be at least 2");
      end
      if (RAW_LAT < 1) begin : g_bad_lat
         $error("warp_issue_sched: RAW_LAT must be at least 1");
      end
      if (LANES != 32) begin : g_bad_lanes
         $error("warp_issue_sched: one issue covers a 32-lane warp");
      end
   endgenerate

   logic [NUM_WARPS-1:0]    eligible;
   logic [NUM_WARPS-1:0]    wait_done;
   logic [NUM_WARPS*CW-1:0] cnt_flat;

   // One countdown per slot and the eligibility of its next instruction
   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      logic arm_w;
      assign arm_w = issue_valid && (issue_warp_id == IDW'(w)) && warp_wr[w];

      warp_raw_timer #(
         .RAW_LAT (RAW_LAT),
         .CW      (CW)
      ) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .arm    (arm_w),
         .remain (cnt_flat[w*CW +: CW]),
         .clear  (wait_done[w])
      );

      assign eligible[w] = warp_valid[w] && (!warp_dep[w] || wait_done[w]);
   end

   warp_rr_picker #(
      .N   (NUM_WARPS),
      .IDW (IDW)
   ) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (eligible),
      .gnt_valid (issue_valid),
      .gnt_id    (issue_warp_id)
   );

   assign idle_cycle = !issue_valid;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
   parameter int NUM_WARPS = 32,
   parameter int RAW_LAT   = 24,
   parameter int IDW       = 5,
   parameter int CW        = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_WARPS-1:0]    warp_valid,
   input  logic [NUM_WARPS-1:0]    warp_dep,
   input  logic [NUM_WARPS-1:0]    warp_wr,
   input  logic                    issue_valid,
   input  logic [IDW-1:0]          issue_warp_id,
   input  logic                    idle_cycle,
   input  logic [NUM_WARPS*CW-1:0] cnt_flat
);

   logic [IDW-1:0] prev_id;
   always_ff @(posedge clk) prev_id <= issue_warp_id;

   // R1 R8
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({issue_valid, idle_cycle}));

   // R2
   valid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> warp_valid[issue_warp_id]);

   // R4
   dep_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && warp_dep[issue_warp_id]) |-> (cnt_flat[issue_warp_id*CW +: CW] == '0));

   // R4
   arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && warp_wr[issue_warp_id]) |=>
         (cnt_flat[prev_id*CW +: CW] == CW'(RAW_LAT - 1)));

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_rng
      // R4
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_flat[w*CW +: CW] <= CW'(RAW_LAT - 1));
   end

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
   .NUM_WARPS (NUM_WARPS),
   .RAW_LAT   (RAW_LAT),
   .IDW       (IDW),
   .CW        (CW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .warp_valid    (warp_valid),
   .warp_dep      (warp_dep),
   .warp_wr       (warp_wr),
   .issue_valid   (issue_valid),
   .issue_warp_id (issue_warp_id),
   .idle_cycle    (idle_cycle),
   .cnt_flat      (cnt_flat)
);

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;

   localparam int N   = 32;
   localparam int LAT = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  warp_valid = '0;
   logic [N-1:0]  warp_dep = '0;
   logic [N-1:0]  warp_wr = '0;
   logic          issue_valid;
   logic [4:0]    issue_warp_id;
   logic          idle_cycle;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   warp_issue_sched u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .warp_valid    (warp_valid),
      .warp_dep      (warp_dep),
      .warp_wr       (warp_wr),
      .issue_valid   (issue_valid),
      .issue_warp_id (issue_warp_id),
      .idle_cycle    (idle_cycle)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // Sample in the current cycle, then move to the next one
   task automatic tick(output bit v, output int id, output bit idl);
      #1;
      v   = issue_valid;
      id  = int'(issue_warp_id);
      idl = idle_cycle;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      warp_valid = '0; warp_dep = '0; warp_wr = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R8 R1: empty pool gives idle only
   task automatic t_reset_state();
      bit v, idl; int id;
      do_reset();
      tick(v, id, idl);
      check(v == 1'b0, "R1 issue with empty pool", v, 0);
      check(idl == 1'b1, "R8 idle with empty pool", idl, 1);
   endtask

   // R2 R3: only slots 3 and 7 occupied, alternate
   task automatic t_valid_mask();
      bit v, idl; int id;
      do_reset();
      warp_valid[3] = 1'b1; warp_valid[7] = 1'b1;
      for (int c = 0; c < 8; c++) begin
         tick(v, id, idl);
         check(v && id == ((c % 2 == 0) ? 3 : 7), "R2 masked slot grant", id, (c % 2 == 0) ? 3 : 7);
      end
   endtask

   // R3: full pool of independent warps rotates 0..31 and wraps
   task automatic t_rotate();
      bit v, idl; int id;
      do_reset();
      warp_valid = '1;
      for (int c = 0; c < 40; c++) begin
         tick(v, id, idl);
         check(v && id == c % N, "R3 round-robin order", id, c % N);
      end
   endtask

   // R4: lone dependent writer waits exactly LAT cycles
   task automatic t_latency();
      bit v, idl; int id; int idles = 0;
      do_reset();
      warp_valid[5] = 1'b1; warp_dep[5] = 1'b1; warp_wr[5] = 1'b1;
      tick(v, id, idl);
      check(v && id == 5, "R4 first dependent issue", id, 5);
      for (int c = 1; c < LAT; c++) begin
         tick(v, id, idl);
         if (!v) idles++;
      end
      check(idles == LAT - 1, "R4 blocked cycles before reissue", idles, LAT - 1);
      tick(v, id, idl);
      check(v && id == 5, "R4 reissue at t+24", v, 1);
   endtask

   // R5: blocked warp 0 skipped in favour of warp 1, then regranted
   task automatic t_skip();
      bit v, idl; int id; int w1 = 0;
      do_reset();
      warp_valid[1:0] = 2'b11; warp_dep[0] = 1'b1; warp_wr[0] = 1'b1;
      tick(v, id, idl);
      check(v && id == 0, "R5 warp0 first", id, 0);
      for (int c = 1; c < LAT; c++) begin
         tick(v, id, idl);
         if (v && id == 1) w1++;
      end
      check(w1 == LAT - 1, "R5 warp1 fills blocked cycles", w1, LAT - 1);
      tick(v, id, idl);
      check(v && id == 0, "R5 warp0 regranted", id, 0);
   endtask

   // R6: writer without dependency issues every cycle
   task automatic t_indep_writer();
      bit v, idl; int id; int hits = 0;
      do_reset();
      warp_valid[9] = 1'b1; warp_wr[9] = 1'b1;
      for (int c = 0; c < 10; c++) begin
         tick(v, id, idl);
         if (v && id == 9) hits++;
      end
      check(hits == 10, "R6 independent issue each cycle", hits, 10);
   endtask

   // R7: occupancy boundary with 24 and with 23 warps
   task automatic t_occupancy();
      bit v, idl; int id; int idles; int badord;
      do_reset();
      warp_valid = 32'h00FF_FFFF; warp_dep = '1; warp_wr = '1;
      idles = 0; badord = 0;
      for (int c = 0; c < 240; c++) begin
         tick(v, id, idl);
         if (idl) idles++;
         if (!v || id != c % 24) badord++;
      end
      check(idles == 0, "R7 24 warps no idle", idles, 0);
      check(badord == 0, "R7 24 warps rotation", badord, 0);
      do_reset();
      warp_valid = 32'h007F_FFFF; warp_dep = '1; warp_wr = '1;
      idles = 0; badord = 0;
      for (int c = 0; c < 240; c++) begin
         tick(v, id, idl);
         if (idl) idles++;
         if (idl != (c % 24 == 23)) badord++;
      end
      check(idles == 10, "R7 23 warps idle count", idles, 10);
      check(badord == 0, "R8 idle placement with 23 warps", badord, 0);
   endtask

   // R9: reset mid-countdown clears the wait
   task automatic t_reset_clears();
      bit v, idl; int id;
      do_reset();
      warp_valid[2] = 1'b1; warp_dep[2] = 1'b1; warp_wr[2] = 1'b1;
      tick(v, id, idl);
      check(v && id == 2, "R9 first issue", id, 2);
      tick(v, id, idl);
      check(idl == 1'b1, "R9 waiting before reset", idl, 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      tick(v, id, idl);
      check(v && id == 2, "R9 eligible right after reset", v, 1);
   endtask

   bit done = 1'b0;

   initial begin
      t_reset_state();
      t_valid_mask();
      t_rotate();
      t_latency();
      t_skip();
      t_indep_writer();
      t_occupancy();
      t_reset_clears();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         report();
         $finish;
      end
   end

endmodule